// File: doc/BRIEF.md
# Seconds Counter with Periodic Interrupt

This block is the clock-function layer of a single-wire timekeeping slave. It keeps a 32-bit count of elapsed seconds, derived from a prescaler that counts a 32.768 kHz enable. Next to the count it holds a control byte. The control byte gates the oscillator (and with it all counting), selects one of eight interrupt intervals and enables an interrupt pulse output. A byte-level link in front of the block delivers the bytes the master writes, requests the bytes the master reads, and strobes a bus reset at the start of every transaction.

Counter data passes through a five-byte shadow buffer in both directions. A read command freezes a snapshot of the count, so a slow master always sees one consistent value. A write command loads the shadow buffer, and the new time reaches the live counter only when the transaction is closed by the next bus reset. The interrupt generator watches one bit of the count, or the top prescaler bit for the one-second setting. A rising edge of that bit, or finding it already set when the control byte is written, starts a pulse four 32.768 kHz periods long.

Top module: `rtc_func_core`

## Requirements
- R1: After power-up reset the count is 0, the control byte reads 00h (oscillator off, interrupt disabled) and `irq` is low.
- R2: While the oscillator is on, the count grows by exactly 1 every 2^PRESC_W enabled ticks, wrapping from FFFFFFFFh to 0. While it is off, the count and prescaler hold.
- R3: The first byte after a bus reset is the command. Command 66h copies the count into the buffer in the cycle the byte arrives. Each following read returns, in a repeating cycle of five, the control byte and then buffer bytes 0 (bits 7:0) to 3 (bits 31:24).
- R4: Command 99h takes the next byte as the control byte, effective from the following cycle. The next four bytes fill buffer bytes 0 to 3 in order. Any further bytes are ignored.
- R5: The buffer is copied into the count, and the prescaler is cleared, only on the bus reset that ends a 99h transaction. A bus reset after any other transaction leaves the count untouched.
- R6: The control byte packs interrupt enable in bit 7, interval select in bits 6:4 and the oscillator enable in bits 3 and 2, with bits 1:0 zero. On write, bit 3 alone sets the oscillator. On read, bits 3 and 2 both show it.
- R7: Interval select 0..7 gives pulse periods of 1, 4, 32, 64, 2048, 4096, 65536 and 131072 seconds. The watched bit is the top prescaler bit for code 0, and count bit 1, 4, 5, 10, 11, 15 or 16 for codes 1 to 7. Each rising edge of the watched bit fires a pulse.
- R8: Every interrupt pulse holds `irq` high for exactly PULSE_TICKS enabled ticks (default 4, about 122 us).
- R9: With the interrupt enable at 0, no pulse starts, and a pulse in progress ends in the next cycle.
- R10: Writing the control byte with the interrupt enable set fires a pulse at once if the watched bit for the new select is already 1. Otherwise the first pulse waits for that bit's next rising edge.
- R11: A command byte other than 66h or 99h makes the block ignore all bytes and read requests until the next bus reset, which then commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| bus_rst | input | 1 | One-cycle strobe: bus reset seen by the link |
| rx_valid | input | 1 | A byte written by the master is present |
| rx_byte | input | 8 | Byte written by the master |
| rd_req | input | 1 | The master wants the next byte |
| tx_valid | output | 1 | `tx_byte` is valid (cycle after `rd_req`) |
| tx_byte | output | 8 | Byte returned to the master |
| irq | output | 1 | Interrupt pulse, active high |

## Verification
Embedded properties check several rules on every cycle. The count either holds, steps by one on a second tick, or takes the buffer on a commit. A frozen oscillator freezes it. Link indices stay within the five-byte cycle, and a halted link never answers. Each pulse starts from a fire event and stays within its length, and a cleared interrupt enable silences `irq` one cycle later. Only the scenarios can show the rest: the snapshot staying constant while the live count moves on, extra write bytes leaving no trace, bit 3 beating bit 2, pulse counts per interval (including the immediate versus delayed first pulse), and 32-bit wraparound.

// File: rtl/rtc_func_pkg.sv
package rtc_func_pkg;

  localparam logic [7:0] CMD_READ  = 8'h66;
  localparam logic [7:0] CMD_WRITE = 8'h99;

  typedef enum logic [1:0] {LK_IDLE, LK_READ, LK_WRITE, LK_HALT} link_st_t;

  typedef struct packed {
    logic       ie;
    logic [2:0] sel;
    logic       osc;
  } ctl_t;

  function automatic logic [7:0] ctl_pack(input ctl_t c);
    return {c.ie, c.sel, c.osc, c.osc, 2'b00};
  endfunction

  // bit 3 alone decides the oscillator; bit 2 is only reported
  function automatic ctl_t ctl_unpack(input logic [7:0] b);
    ctl_t c;
    c.ie  = b[7];
    c.sel = b[6:4];
    c.osc = b[3];
    return c;
  endfunction

  // count bit whose rising edge marks one interval; code 0 uses the prescaler
  function automatic int unsigned tap_pos(input logic [2:0] sel);
    case (sel)
      3'd1:    return 1;
      3'd2:    return 4;
      3'd3:    return 5;
      3'd4:    return 10;
      3'd5:    return 11;
      3'd6:    return 15;
      3'd7:    return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int PRESC_W = 15,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               osc_en,
  input  logic               commit,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   count,
  output logic               presc_msb,
  output logic               sec_tick
);
  logic [PRESC_W-1:0] presc;

  assign sec_tick  = osc_en & tick & (&presc);
  assign presc_msb = presc[PRESC_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      count <= '0;
    end else if (commit) begin
      presc <= '0;
      count <= load_val;
    end else if (osc_en && tick) begin
      presc <= presc + PRESC_W'(1);
      if (sec_tick) count <= count + CNT_W'(1);
    end
  end

  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !sec_tick) |=> $stable(count)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !commit) |=> (count == $past(count) + CNT_W'(1))); // R2
  AST_OSC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !commit) |=> ($stable(count) && $stable(presc_msb))); // R2
  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (count == $past(load_val))); // R5
endmodule

// File: rtl/rtc_link_ctrl.sv
module rtc_link_ctrl
  import rtc_func_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rst,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               rd_req,
  input  logic [CNT_W-1:0]   count,
  output logic               tx_valid,
  output logic [7:0]         tx_byte,
  output ctl_t               ctl,
  output logic               ctl_wr,
  output logic               commit,
  output logic [CNT_W-1:0]   load_val
);
  localparam int NBYTES = CNT_W / 8;
  localparam int IDX_W  = $clog2(NBYTES + 2);

  link_st_t          state;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  rw_buf;
  logic [7:0]        rd_sel;

  assign load_val = rw_buf;

  always_comb begin
    rd_sel = ctl_pack(ctl);
    for (int b = 0; b < NBYTES; b++)
      if (idx == IDX_W'(b + 1)) rd_sel = rw_buf[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LK_IDLE;
      idx      <= '0;
      rw_buf   <= '0;
      ctl      <= '0;
      ctl_wr   <= 1'b0;
      commit   <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      ctl_wr   <= 1'b0;
      commit   <= 1'b0;
      tx_valid <= 1'b0;
      if (bus_rst) begin
        commit <= (state == LK_WRITE);
        state  <= LK_IDLE;
        idx    <= '0;
      end else begin
        case (state)
          LK_IDLE: if (rx_valid) begin
            idx <= '0;
            if (rx_byte == CMD_READ) begin
              rw_buf <= count;
              state  <= LK_READ;
            end else if (rx_byte == CMD_WRITE) begin
              rw_buf <= count;
              state  <= LK_WRITE;
            end else begin
              state  <= LK_HALT;
            end
          end
          LK_READ: if (rd_req) begin
            tx_valid <= 1'b1;
            tx_byte  <= rd_sel;
            idx      <= (idx == IDX_W'(NBYTES)) ? '0 : idx + IDX_W'(1);
          end
          LK_WRITE: if (rx_valid && idx <= IDX_W'(NBYTES)) begin
            if (idx == '0) begin
              ctl    <= ctl_unpack(rx_byte);
              ctl_wr <= 1'b1;
            end
            for (int b = 0; b < NBYTES; b++)
              if (idx == IDX_W'(b + 1)) rw_buf[8*b +: 8] <= rx_byte;
            idx <= idx + IDX_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  AST_RD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_READ) |-> (idx <= IDX_W'(NBYTES))); // R3
  AST_WR_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_WRITE) |-> (idx <= IDX_W'(NBYTES + 1))); // R4
  AST_RST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (state == LK_IDLE)); // R11
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_HALT) |=> !tx_valid); // R11
  AST_CTL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && $past(idx == '0) |-> (tx_byte[1:0] == 2'b00 && tx_byte[3] == tx_byte[2])); // R6
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse
  import rtc_func_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PULSE_TICKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               ie,
  input  logic [2:0]         sel,
  input  logic               ctl_wr,
  input  logic [CNT_W-1:0]   count,
  input  logic               presc_msb,
  output logic               fire,
  output logic               irq
);
  localparam int TAP_W = $clog2(CNT_W);
  localparam int PC_W  = $clog2(PULSE_TICKS + 1);

  logic [TAP_W-1:0] tap_idx;
  logic             tap_now, tap_q;
  logic [PC_W-1:0]  pulse_cnt;

  assign tap_idx = TAP_W'(tap_pos(sel));
  assign tap_now = (sel == 3'd0) ? presc_msb : count[tap_idx];
  assign fire    = ie & tap_now & (~tap_q | ctl_wr);
  assign irq     = (pulse_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      tap_q <= tap_now;
      if (!ie)                          pulse_cnt <= '0;
      else if (fire)                    pulse_cnt <= PC_W'(PULSE_TICKS);
      else if (tick && pulse_cnt != '0) pulse_cnt <= pulse_cnt - PC_W'(1);
    end
  end

  AST_IE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !irq); // R9
  AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire)); // R8
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PC_W'(PULSE_TICKS)); // R8
endmodule

// File: rtl/rtc_func_core.sv
module rtc_func_core
  import rtc_func_pkg::*;
#(
  parameter int PRESC_W     = 15,
  parameter int CNT_W       = 32,
  parameter int PULSE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       bus_rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rd_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       irq
);
  ctl_t             ctl;
  logic             ctl_wr, commit, sec_tick, presc_msb, fire;
  logic [CNT_W-1:0] count, load_val;

  rtc_sec_counter #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .osc_en(ctl.osc),
    .commit(commit), .load_val(load_val), .count(count),
    .presc_msb(presc_msb), .sec_tick(sec_tick));

  rtc_link_ctrl #(.CNT_W(CNT_W)) u_link (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_req(rd_req), .count(count),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .ctl(ctl), .ctl_wr(ctl_wr),
    .commit(commit), .load_val(load_val));

  rtc_irq_pulse #(.CNT_W(CNT_W), .PULSE_TICKS(PULSE_TICKS)) u_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .ie(ctl.ie), .sel(ctl.sel),
    .ctl_wr(ctl_wr), .count(count), .presc_msb(presc_msb),
    .fire(fire), .irq(irq));

  AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst_n) |=> !irq); // R1
  AST_TICK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> ctl.osc && tick_32k); // R2
endmodule

// File: tb/test_rtc_func_core.sv
module test_rtc_func_core;
  localparam int PW = 4;  // one second = 16 clocks with tick every cycle

  logic clk = 0, rst_n = 0, tick_32k = 1, bus_rst = 0;
  logic rx_valid = 0, rd_req = 0;
  logic [7:0] rx_byte = 0;
  logic tx_valid, irq;
  logic [7:0] tx_byte;

  int checks = 0, failures = 0;
  int cyc = 0, rises = 0, hi_len = 0, last_w = 0, n_rst = 0;
  logic irq_q = 0;
  logic [7:0] exp_q[$];
  string req_q[$];

  rtc_func_core #(.PRESC_W(PW)) i_rtc_func_core (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_rst(bus_rst),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for returned bytes and irq edge/width tracking
  always @(negedge clk) begin
    if (tx_valid) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected byte", tx_byte, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(tx_byte == e, r, tx_byte, e);
      end
    end
    if (irq && !irq_q) rises++;
    if (irq) hi_len++;
    else if (irq_q) begin last_w = hi_len; hi_len = 0; end
    irq_q = irq;
  end

  task automatic bus_reset();
    @(negedge clk); n_rst = cyc; bus_rst = 1;
    @(negedge clk); bus_rst = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rd(input logic [7:0] e, input string r);
    @(negedge clk); rd_req = 1; exp_q.push_back(e); req_q.push_back(r);
    @(negedge clk); rd_req = 0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_frame(input logic [7:0] c, input logic [31:0] v, input string r);
    rd(c, r);
    for (int i = 0; i < 4; i++) rd(v[8*i +: 8], r);
  endtask

  task automatic write_all(input logic [7:0] c, input logic [31:0] v);
    bus_reset(); send(8'h99); send(c);
    for (int i = 0; i < 4; i++) send(v[8*i +: 8]);
    bus_reset();
  endtask

  function automatic logic [31:0] secs_at(input logic [31:0] base, input int m, input int n);
    return base + 32'((m - n - 2) / 16);
  endfunction

  initial begin
    int r0, base_n;
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        check(irq == 0, "R1 irq low after reset", irq, 0);
        // R1 / R3: reset contents, repeating five-byte cycle
        bus_reset(); send(8'h66);
        rd_frame(8'h00, 32'h0, "R1 reset contents");
        rd(8'h00, "R3 wrap to control byte");
        // R4: write with a sixth byte ignored; R3 repeat
        bus_reset(); send(8'h99); send(8'h00);
        send(8'h78); send(8'h56); send(8'h34); send(8'h12); send(8'hAB);
        bus_reset(); idle(100);
        bus_reset(); send(8'h66);
        rd_frame(8'h00, 32'h12345678, "R4 write order and extra byte");
        rd(8'h00, "R3 second pass"); rd(8'h78, "R3 second pass");
        // R6: bit 2 alone does not start oscillator; R2 frozen
        write_all(8'h04, 32'h12345678); idle(100);
        bus_reset(); send(8'h66);
        rd_frame(8'h00, 32'h12345678, "R6 bit2 alone / R2 frozen");
        // R6 bit 3 alone starts oscillator, R2 counting
        write_all(8'h08, 32'h00000010); base_n = n_rst;
        wait_until(base_n + 2 + 88); send(8'h66);
        rd_frame(8'h0C, secs_at(32'h10, base_n + 2 + 88, base_n), "R2 count rate / R6 read form");
        // R3 snapshot while count moves; R5 read-end reset does not commit
        write_all(8'h08, 32'h000000FF); base_n = n_rst;
        wait_until(base_n + 10); send(8'h66);
        rd_frame(8'h0C, 32'hFF, "R3 snapshot");
        idle(60);
        rd_frame(8'h0C, 32'hFF, "R3 snapshot held");
        bus_reset();
        wait_until(base_n + 202); send(8'h66);
        rd_frame(8'h0C, 32'h10B, "R5 no commit after read");
        // R2 wraparound
        write_all(8'h08, 32'hFFFFFFFF); base_n = n_rst;
        wait_until(base_n + 2 + 24); send(8'h66);
        rd_frame(8'h0C, 32'h0, "R2 wrap to zero");
        // R10 immediate pulse: watched bit already set, oscillator off
        write_all(8'h00, 32'h3);
        bus_reset(); send(8'h99); r0 = rises;
        send(8'h90); idle(3);
        check(rises - r0 == 1, "R10 immediate pulse", rises - r0, 1);
        send(8'h03); send(8'h00); send(8'h00); send(8'h00); bus_reset();
        idle(100);
        check(rises - r0 == 1, "R10 no repeat while frozen", rises - r0, 1);
        // R10 delayed: watched bit clear
        write_all(8'h00, 32'h0);
        bus_reset(); send(8'h99); r0 = rises; send(8'h90); idle(10);
        check(rises == r0, "R10 no immediate pulse", rises - r0, 0);
        send(8'h00); send(8'h00); send(8'h00); send(8'h00); bus_reset();
        // R7 code 1 (4 s) and R8 width
        write_all(8'h98, 32'h0); r0 = rises; idle(120);
        check(rises - r0 == 2, "R7 four-second interval", rises - r0, 2);
        check(last_w == 4, "R8 pulse width", last_w, 4);
        // R7 code 0 (1 s)
        write_all(8'h88, 32'h0); r0 = rises; idle(50);
        check(rises - r0 == 3, "R7 one-second interval", rises - r0, 3);
        // R7 code 6 (count bit 15)
        write_all(8'hE8, 32'h00007FFE); r0 = rises; idle(20);
        check(rises == r0, "R7 code6 no early pulse", rises - r0, 0);
        idle(40);
        check(rises - r0 == 1, "R7 code6 pulse on bit15", rises - r0, 1);
        // R9 enable clear: no pulses
        write_all(8'h18, 32'h0); r0 = rises; idle(120);
        check(rises == r0 && irq == 0, "R9 disabled interrupt", rises - r0, 0);
        // R11 unknown command halts link
        write_all(8'h00, 32'hCAFEF00D);
        bus_reset(); send(8'h33);
        @(negedge clk); rd_req = 1; @(negedge clk); rd_req = 0;
        send(8'h99); send(8'h00); send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        bus_reset(); send(8'h66);
        rd_frame(8'h00, 32'hCAFEF00D, "R11 halted link changes nothing");
        idle(4);
        check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
      end
      begin
        repeat (60000) @(negedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule